// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block links an A port and a B port through two independent 8-bit halves. In each half, each direction has its own capture register, a choice between live and stored data, and an output enable. The A-to-B enable is active high and the B-to-A enable is active low. The two halves can work as two separate byte-wide transceivers, or be driven with the same controls to act as one 16-bit transceiver.

Each tri-state bus is split into an input value, an output value and a per-half output enable. The value seen on a port is the block's own output while the block drives that port, and the external input otherwise. Each register captures the value seen on its source port at a rising edge of its capture strobe. The strobes are level inputs sampled on the system clock, so a capture lands at the first clock edge on which the strobe is seen high after being low. The select and enable levels do not affect capture.

When both directions of a half are enabled in live mode, each port would only echo the other. A per-half keeper register breaks that loop. Outside this mode the keeper follows the value seen on the A port at every clock. In this mode it freezes, and both ports are driven with the frozen value.

The data pins carry plain bus values rather than a stream, so no valid/ready handshake applies to them. All control pins are plain levels.

Top module: `dual_bus_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both capture registers and the keeper of every half, so stored-mode outputs read zero after reset.
- R2: The A-to-B register of a half loads the seen A value on the first clock at which its strobe `cap_ab` is high after being low, whatever the enable and select levels are.
- R3: The B-to-A register of a half loads the seen B value on the first clock at which its strobe `cap_ba` is high after being low, whatever the enable and select levels are.
- R4: A strobe held high loads only once. Input changes while the strobe stays high leave the register unchanged.
- R5: With a select low (0 = live), the driven port copies the seen value of the opposite port in the same cycle: `pick_ab` low routes A to B, and `pick_ba` low routes B to A.
- R6: With a select high (1 = stored), the driven port carries that direction's register contents and ignores changes on the opposite port.
- R7: `b_oe` of a half equals its `drv_b_en` (active high) and `a_oe` equals the inverse of `drv_a_en_n` (active low). `drv_b_en`=0 with `drv_a_en_n`=1 leaves both ports undriven.
- R8: With both directions enabled and both selects high, stored A data drives B and stored B data drives A at the same time.
- R9: With the A port driven from live B, one capture on both strobes together loads the B value into both registers.
- R10: With both directions enabled and both selects low, both ports carry the keeper value. This is the last value seen on A before the mode was entered, and it holds while the external inputs change.
- R11: The halves are independent. Bits [7:0] and enable bit 0 belong to half 0, and bits [15:8] and enable bit 1 belong to half 1. Controls of one half do not change the outputs or registers of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | Value driven onto the A port from outside |
| a_out | output | 16 | Value the block drives onto the A port |
| a_oe | output | 2 | Per-half A drive enable |
| b_in | input | 16 | Value driven onto the B port from outside |
| b_out | output | 16 | Value the block drives onto the B port |
| b_oe | output | 2 | Per-half B drive enable |
| drv_b_en | input | 2 | Per-half A-to-B enable, active high |
| drv_a_en_n | input | 2 | Per-half B-to-A enable, active low |
| pick_ab | input | 2 | Per-half B source select: 0 live A, 1 stored |
| pick_ba | input | 2 | Per-half A source select: 0 live B, 1 stored |
| cap_ab | input | 2 | Per-half A-to-B capture strobe (rising edge) |
| cap_ba | input | 2 | Per-half B-to-A capture strobe (rising edge) |

## Verification
The hardest case to reach is the mutual-reinforce mode. Its result depends on what the keeper sampled before the mode was entered, so a test that enables both directions from reset shows only zeros. The stimulus therefore first runs a live A-to-B phase for at least one clock with a distinct A value, which loads the keeper, and only then enables the B-to-A direction. It then moves both external inputs to unrelated values for several clocks while the outputs are watched. Registers are read only through the stored-mode outputs, so each capture test ends by switching that half to stored mode.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Source feeding one port's output driver.
  typedef enum logic [1:0] {
    PATH_OFF    = 2'd0,
    PATH_LIVE   = 2'd1,
    PATH_STORED = 2'd2,
    PATH_KEEP   = 2'd3
  } path_e;

  // own_en: this port driven; own_sel: stored data for this port.
  // far_en/far_sel: same controls for the opposite direction.
  function automatic path_e pick_path(input logic own_en, input logic own_sel,
                                      input logic far_en, input logic far_sel);
    path_e p;
    if (!own_en)                p = PATH_OFF;
    else if (own_sel)           p = PATH_STORED;
    else if (far_en && !far_sel) p = PATH_KEEP;
    else                        p = PATH_LIVE;
    return p;
  endfunction

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign rise = lvl && !prev_q && !rst;

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R4

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (q == '0)); // R1
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(d))); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q)); // R4

endmodule

// File: rtl/xcvr_keeper.sv
module xcvr_keeper #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (!hold) q <= d;
  end

  AST_KEEP_FROZEN: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(q)); // R10

endmodule

// File: rtl/xcvr_half.sv
module xcvr_half
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         en_ab,
  input  logic         en_ba_n,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         cap_ab,
  input  logic         cap_ba,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  path_e       pa, pb;
  logic        en_ba;
  logic        loop_mode;
  logic        rise_ab, rise_ba;
  logic [W-1:0] reg_ab, reg_ba, keep_q;
  logic [W-1:0] a_seen, b_seen;

  assign en_ba = !en_ba_n;
  assign pa = pick_path(en_ba, sel_ba, en_ab, sel_ab);
  assign pb = pick_path(en_ab, sel_ab, en_ba, sel_ba);
  assign loop_mode = (pa == PATH_KEEP);

  // Output drivers. In live mode the opposite port is either external or
  // driven from its register; the looping case goes through the keeper.
  always_comb begin
    unique case (pa)
      PATH_STORED: a_out = reg_ba;
      PATH_KEEP:   a_out = keep_q;
      PATH_LIVE:   a_out = (pb == PATH_STORED) ? reg_ab : b_in;
      default:     a_out = '0;
    endcase
    unique case (pb)
      PATH_STORED: b_out = reg_ab;
      PATH_KEEP:   b_out = keep_q;
      PATH_LIVE:   b_out = (pa == PATH_STORED) ? reg_ba : a_in;
      default:     b_out = '0;
    endcase
  end

  assign a_oe   = (pa != PATH_OFF);
  assign b_oe   = (pb != PATH_OFF);
  assign a_seen = a_oe ? a_out : a_in;
  assign b_seen = b_oe ? b_out : b_in;

  xcvr_edge u_edge_ab (.clk(clk), .rst(rst), .lvl(cap_ab), .rise(rise_ab));
  xcvr_edge u_edge_ba (.clk(clk), .rst(rst), .lvl(cap_ba), .rise(rise_ba));

  xcvr_store #(.W(W)) u_reg_ab (
    .clk(clk), .rst(rst), .load(rise_ab), .d(a_seen), .q(reg_ab));
  xcvr_store #(.W(W)) u_reg_ba (
    .clk(clk), .rst(rst), .load(rise_ba), .d(b_seen), .q(reg_ba));

  xcvr_keeper #(.W(W)) u_keep (
    .clk(clk), .rst(rst), .hold(loop_mode), .d(a_seen), .q(keep_q));

  AST_LOOP_STEADY: assert property (@(posedge clk) disable iff (rst)
    loop_mode |=> (!loop_mode || ($stable(a_out) && $stable(b_out)))); // R10
  AST_LOOP_AGREE: assert property (@(posedge clk) disable iff (rst)
    loop_mode |-> (a_out == b_out)); // R10
  AST_ISOLATED: assert property (@(posedge clk) disable iff (rst)
    (!en_ab && en_ba_n) |-> (!a_oe && !b_oe)); // R7
  AST_SWAP_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (en_ab && !en_ba_n && sel_ab && sel_ba) |-> (a_out == reg_ba && b_out == reg_ab)); // R8

endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr #(
  parameter int HALF_W = 8,
  parameter int HALVES = 2,
  localparam int BUS_W = HALF_W * HALVES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  a_in,
  output logic [BUS_W-1:0]  a_out,
  output logic [HALVES-1:0] a_oe,
  input  logic [BUS_W-1:0]  b_in,
  output logic [BUS_W-1:0]  b_out,
  output logic [HALVES-1:0] b_oe,
  input  logic [HALVES-1:0] drv_b_en,
  input  logic [HALVES-1:0] drv_a_en_n,
  input  logic [HALVES-1:0] pick_ab,
  input  logic [HALVES-1:0] pick_ba,
  input  logic [HALVES-1:0] cap_ab,
  input  logic [HALVES-1:0] cap_ba
);
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    xcvr_half #(.W(HALF_W)) u_half (
      .clk     (clk),
      .rst     (rst),
      .a_in    (a_in[h*HALF_W +: HALF_W]),
      .b_in    (b_in[h*HALF_W +: HALF_W]),
      .en_ab   (drv_b_en[h]),
      .en_ba_n (drv_a_en_n[h]),
      .sel_ab  (pick_ab[h]),
      .sel_ba  (pick_ba[h]),
      .cap_ab  (cap_ab[h]),
      .cap_ba  (cap_ba[h]),
      .a_out   (a_out[h*HALF_W +: HALF_W]),
      .a_oe    (a_oe[h]),
      .b_out   (b_out[h*HALF_W +: HALF_W]),
      .b_oe    (b_oe[h])
    );
  end

endmodule

// File: tb/dual_bus_xcvr_test.sv
module dual_bus_xcvr_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a_in = '0, b_in = '0;
  logic [15:0] a_out, b_out;
  logic [1:0]  a_oe, b_oe;
  logic [1:0]  drv_b_en = 2'b00, drv_a_en_n = 2'b11;
  logic [1:0]  pick_ab = 2'b00, pick_ba = 2'b00;
  logic [1:0]  cap_ab = 2'b00, cap_ba = 2'b00;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_bus_xcvr uut (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .drv_b_en(drv_b_en),
    .drv_a_en_n(drv_a_en_n), .pick_ab(pick_ab), .pick_ba(pick_ba),
    .cap_ab(cap_ab), .cap_ba(cap_ba));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic isolate();
    drv_b_en = 2'b00; drv_a_en_n = 2'b11; pick_ab = 2'b00; pick_ba = 2'b00;
  endtask

  task automatic show_stored();
    drv_b_en = 2'b11; drv_a_en_n = 2'b00; pick_ab = 2'b11; pick_ba = 2'b11;
    #1;
  endtask

  task automatic pulse(input logic [1:0] ab, input logic [1:0] ba);
    @(negedge clk); cap_ab = ab; cap_ba = ba;
    @(negedge clk); cap_ab = 2'b00; cap_ba = 2'b00;
    #1;
  endtask

  task automatic t_reset();
    isolate(); settle();
    chk("R7 isolated a_oe", {14'd0, a_oe}, 16'd0);
    chk("R7 isolated b_oe", {14'd0, b_oe}, 16'd0);
    show_stored();
    chk("R1 reset reg_ab", b_out, 16'h0000);
    chk("R1 reset reg_ba", a_out, 16'h0000);
    isolate();
  endtask

  task automatic t_capture_swap();
    isolate(); a_in = 16'hA55A; b_in = 16'h3CC3;
    pulse(2'b11, 2'b11);
    show_stored();
    chk("R7 enabled b_oe", {14'd0, b_oe}, 16'h0003);
    chk("R7 enabled a_oe", {14'd0, a_oe}, 16'h0003);
    chk("R2 R8 stored A on B", b_out, 16'hA55A);
    chk("R3 R8 stored B on A", a_out, 16'h3CC3);
    a_in = 16'h1357; b_in = 16'h2468; #1;
    chk("R6 stored ignores live A", b_out, 16'hA55A);
    chk("R6 stored ignores live B", a_out, 16'h3CC3);
    isolate();
  endtask

  task automatic t_no_retrigger();
    isolate(); a_in = 16'h1111;
    @(negedge clk); cap_ab = 2'b11;
    @(negedge clk); a_in = 16'h2222;
    repeat (3) @(negedge clk);
    cap_ab = 2'b00; #1;
    drv_b_en = 2'b11; pick_ab = 2'b11; #1;
    chk("R4 held strobe loads once", b_out, 16'h1111);
    isolate();
  endtask

  task automatic t_live();
    isolate(); drv_b_en = 2'b11; a_in = 16'h5A5A; #1;
    chk("R5 live A to B", b_out, 16'h5A5A);
    a_in = 16'h0F0F; #1;
    chk("R5 live follows A", b_out, 16'h0F0F);
    chk("R7 A undriven", {14'd0, a_oe}, 16'd0);
    isolate(); drv_a_en_n = 2'b00; b_in = 16'h7E81; #1;
    chk("R5 live B to A", a_out, 16'h7E81);
    chk("R7 B undriven", {14'd0, b_oe}, 16'd0);
    isolate();
  endtask

  task automatic t_same_data();
    isolate(); drv_a_en_n = 2'b00; b_in = 16'hBEEF; a_in = 16'h1234;
    pulse(2'b11, 2'b11);
    show_stored();
    chk("R9 reg_ab got B", b_out, 16'hBEEF);
    chk("R9 reg_ba got B", a_out, 16'hBEEF);
    isolate();
  endtask

  task automatic t_loop();
    isolate(); drv_b_en = 2'b11; a_in = 16'hC0DE; b_in = 16'h0000;
    settle(); settle();
    drv_a_en_n = 2'b00; #1;
    chk("R10 loop A", a_out, 16'hC0DE);
    chk("R10 loop B", b_out, 16'hC0DE);
    a_in = 16'hFFFF; b_in = 16'h5555;
    repeat (3) settle();
    chk("R10 loop holds A", a_out, 16'hC0DE);
    chk("R10 loop holds B", b_out, 16'hC0DE);
    isolate();
  endtask

  task automatic t_independent();
    isolate(); a_in = 16'h4477;
    pulse(2'b11, 2'b00);
    drv_b_en = 2'b01; pick_ab = 2'b01; a_in = 16'h9900; #1;
    chk("R11 half1 undriven", {14'd0, b_oe}, 16'h0001);
    pulse(2'b10, 2'b00);
    chk("R11 half0 unaffected", {8'd0, b_out[7:0]}, 16'h0077);
    drv_b_en = 2'b11; pick_ab = 2'b11; #1;
    chk("R11 half1 own capture", b_out, 16'h9977);
    isolate();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_capture_swap();
    t_no_retrigger();
    t_live();
    t_same_data();
    t_loop();
    t_independent();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule